// File: doc/BRIEF.md
# Smooth Clock Calibration Unit

This block trims the rate of a slow timekeeping clock without adjusting the oscillator. It runs on that clock and outputs a per-cycle enable count for the prescaler chain. The count says how many times the prescaler advances in the current input cycle. To slow the clock down, the block withholds a programmable number of advances in each calibration window. To speed it up, it can insert a fixed block of extra advances. The corrections are spread evenly across the window, so the timebase is trimmed to ppm resolution and never takes a visible phase step.

The window is 2^WIN_W input cycles. With the default of 20, that is 32 seconds at 32768 Hz. A short-window mode halves the window. A new setting arrives through a one-cycle write strobe. It is held in a shadow register and goes live only at the next window boundary. A pending output stays high until the new setting is live.

Top module: `smcal_top`

## Requirements
- R1: After reset, the live and shadow settings are zero, `cal_pend` is 0, and with zero settings `en_cnt` is 1 in every cycle, so a full window sums to 2^WIN_W.
- R2: `en_cnt` is encoded as 0 (advance withheld), 1 (normal advance) or 2 (double advance). The value 3 never appears.
- R3: In long-window mode (`wr_half`=0), with `wr_add`=0, the sum of `en_cnt` over one 2^WIN_W-cycle window is 2^WIN_W − dec, for any dec from 0 to 511.
- R4: With `wr_add`=1 in long-window mode, the window sum is 2^WIN_W + 512 − dec.
- R5: In short-window mode, the window is 2^(WIN_W−1) cycles. The least significant bit of dec is ignored. Each short window sums to 2^(WIN_W−1) + 256·add − floor(dec/2).
- R6: A withheld advance can only fall on a window position that is a multiple of 2^(WIN_W−9). Two consecutive cycles are never both withheld.
- R7: A double advance can only fall on a position p where p mod 2^(WIN_W−9) equals 2^(WIN_W−10). The cycle after a double advance is a normal advance.
- R8: A write raises `cal_pend` on the next cycle. The written value does not alter `en_cnt` before the next window boundary.
- R9: `cal_pend` falls only at a window boundary. The new setting governs the whole of the following window.
- R10: A write made in the last cycle of a window is not applied at that boundary. `cal_pend` stays high, and the value is applied at the following boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timekeeping clock being trimmed |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle strobe that loads a new setting into the shadow register |
| wr_dec | input | 9 | Number of advances to withhold per window |
| wr_add | input | 1 | Insert 512 extra advances per long window |
| wr_half | input | 1 | Select the half-length window |
| en_cnt | output | 2 | Prescaler advances in this cycle (0, 1 or 2) |
| cal_pend | output | 1 | A written setting is waiting for a window boundary |

## Verification
`en_cnt` is combinational from the window counter and the live setting, so its value is due in the same cycle the counter shows a position. `cal_pend` is registered and is due one cycle after the write strobe. A new setting is due from the first cycle after the next boundary. The bench keeps its own position counter, aligned to reset release. It samples on the falling edge, checks `cal_pend` at the last and first positions around each boundary, and compares whole-window sums only for windows that lie entirely under a single setting. The window in which a write lands is compared against the previous setting whenever that setting used long windows.

// File: rtl/smcal_pkg.sv
package smcal_pkg;

   localparam int CAL_DEC_W = 9;

   typedef struct packed {
      logic [CAL_DEC_W-1:0] dec;
      logic                 add;
      logic                 half;
   } cal_cfg_t;

   typedef enum logic [1:0] {
      ADV_NONE = 2'd0,
      ADV_ONE  = 2'd1,
      ADV_TWO  = 2'd2
   } adv_e;

   function automatic logic [CAL_DEC_W-1:0] rev_bits(input logic [CAL_DEC_W-1:0] v);
      logic [CAL_DEC_W-1:0] r;
      for (int i = 0; i < CAL_DEC_W; i++) r[i] = v[CAL_DEC_W-1-i];
      return r;
   endfunction

endpackage

// File: rtl/smcal_wincnt.sv
module smcal_wincnt #(
   parameter int WIN_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             half,
   output logic [WIN_W-1:0] pos,
   output logic             win_end
);
   logic long_end;
   logic short_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pos <= '0;
      else        pos <= pos + 1'b1;
   end

   assign short_end = &pos[WIN_W-2:0];
   assign long_end  = short_end & pos[WIN_W-1];
   assign win_end   = half ? short_end : long_end;

endmodule

// File: rtl/smcal_cfg.sv
module smcal_cfg
   import smcal_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     wr_en,
   input  cal_cfg_t wr_cfg,
   input  logic     win_end,
   output cal_cfg_t live_cfg,
   output logic     pend
);
   cal_cfg_t shadow;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow   <= '0;
         live_cfg <= '0;
         pend     <= 1'b0;
      end else begin
         if (win_end) live_cfg <= shadow;
         if (wr_en) begin
            shadow <= wr_cfg;
            pend   <= 1'b1;
         end else if (win_end) begin
            pend   <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/smcal_slot.sv
module smcal_slot
   import smcal_pkg::*;
#(
   parameter int WIN_W   = 20,
   parameter bit HAS_ADD = 1'b1
) (
   input  logic [WIN_W-1:0] pos,
   input  cal_cfg_t         cfg,
   output adv_e             adv
);
   localparam int SUB_W = WIN_W - CAL_DEC_W;
   localparam logic [SUB_W-1:0] ADD_PH = {1'b1, {(SUB_W-1){1'b0}}};

   logic [CAL_DEC_W-1:0] hi;
   logic [CAL_DEC_W-1:0] key;
   logic [CAL_DEC_W-1:0] lim;
   logic                 slot0;
   logic                 drop;
   logic                 dbl;

   assign hi    = pos[WIN_W-1:SUB_W];
   assign slot0 = (pos[SUB_W-1:0] == '0);

   always_comb begin
      if (cfg.half) begin
         key = rev_bits({1'b0, hi[CAL_DEC_W-2:0]});
         lim = {cfg.dec[CAL_DEC_W-1:1], 1'b0};
      end else begin
         key = rev_bits(hi);
         lim = cfg.dec;
      end
   end

   assign drop = slot0 && (key < lim);

   generate
      if (HAS_ADD) begin : g_add
         assign dbl = cfg.add && (pos[SUB_W-1:0] == ADD_PH);
      end else begin : g_noadd
         assign dbl = 1'b0;
      end
   endgenerate

   always_comb begin
      if (drop)     adv = ADV_NONE;
      else if (dbl) adv = ADV_TWO;
      else          adv = ADV_ONE;
   end

endmodule

// File: rtl/smcal_top.sv
module smcal_top
   import smcal_pkg::*;
#(
   parameter int WIN_W   = 20,
   parameter bit HAS_ADD = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [8:0] wr_dec,
   input  logic       wr_add,
   input  logic       wr_half,
   output logic [1:0] en_cnt,
   output logic       cal_pend
);
   generate
      if (WIN_W < CAL_DEC_W + 2) begin : g_bad_win
         $error("smcal_top: WIN_W must be at least CAL_DEC_W+2");
      end
   endgenerate

   logic [WIN_W-1:0] pos;
   logic             win_end;
   cal_cfg_t         live_cfg;
   cal_cfg_t         wr_cfg;
   adv_e             adv;

   assign wr_cfg = '{dec: wr_dec, add: wr_add, half: wr_half};

   smcal_wincnt #(.WIN_W(WIN_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .half    (live_cfg.half),
      .pos     (pos),
      .win_end (win_end)
   );

   smcal_cfg u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_cfg   (wr_cfg),
      .win_end  (win_end),
      .live_cfg (live_cfg),
      .pend     (cal_pend)
   );

   smcal_slot #(.WIN_W(WIN_W), .HAS_ADD(HAS_ADD)) u_slot (
      .pos (pos),
      .cfg (live_cfg),
      .adv (adv)
   );

   assign en_cnt = adv;

endmodule

// File: rtl/smcal_chk.sv
module smcal_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic       pend,
   input logic [1:0] en_cnt,
   input logic       win_end
);
   // R2
   enc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_cnt != 2'd3);

   // R6
   drop_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_cnt == 2'd0) |=> (en_cnt != 2'd0));

   // R7
   dbl_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_cnt == 2'd2) |=> (en_cnt == 2'd1));

   // R8
   pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> pend);

   // R9
   pend_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend) |-> $past(win_end));

endmodule

bind smcal_top smcal_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .pend    (cal_pend),
   .en_cnt  (en_cnt),
   .win_end (win_end)
);

// File: tb/sim_smcal_top.sv
module sim_smcal_top;
   localparam int W   = 11;
   localparam int WIN = 1 << W;
   localparam int SUB = 1 << (W - 9);

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [8:0] wr_dec = '0;
   logic       wr_add = 1'b0;
   logic       wr_half = 1'b0;
   logic [1:0] en_cnt;
   logic       cal_pend;

   int checks = 0;
   int errors = 0;
   int p = 0;
   int acc = 0;
   int last_sum = 0;
   bit bad_enc, bad_drop, bad_dbl;
   bit done = 1'b0;

   always #10 clk = ~clk;

   smcal_top #(.WIN_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_dec(wr_dec),
      .wr_add(wr_add), .wr_half(wr_half), .en_cnt(en_cnt), .cal_pend(cal_pend)
   );

   // {dec[26:18], add[17], half[16], expected sum over WIN cycles [15:0]}
   localparam logic [26:0] VEC [12] = '{
      {9'd0,   1'b0, 1'b0, 16'd2048},
      {9'd100, 1'b0, 1'b0, 16'd1948},
      {9'd511, 1'b0, 1'b0, 16'd1537},
      {9'd0,   1'b1, 1'b0, 16'd2560},
      {9'd300, 1'b1, 1'b0, 16'd2260},
      {9'd511, 1'b1, 1'b0, 16'd2049},
      {9'd0,   1'b0, 1'b1, 16'd2048},
      {9'd201, 1'b0, 1'b1, 16'd1848},
      {9'd200, 1'b0, 1'b1, 16'd1848},
      {9'd511, 1'b1, 1'b1, 16'd2050},
      {9'd7,   1'b1, 1'b0, 16'd2553},
      {9'd0,   1'b0, 1'b0, 16'd2048}
   };

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      if (en_cnt == 2'd3) bad_enc = 1'b1;
      if (en_cnt == 2'd0 && (p % SUB) != 0) bad_drop = 1'b1;
      if (en_cnt == 2'd2 && (p % SUB) != SUB / 2) bad_dbl = 1'b1;
      acc += int'(en_cnt);
      if (p == WIN - 1) begin
         last_sum = acc;
         acc = 0;
      end
      @(negedge clk);
      p = (p + 1) % WIN;
   endtask

   task automatic run_to(input int target);
      while (p != target) step();
   endtask

   task automatic write_cfg(input logic [8:0] d, input logic a, input logic h);
      wr_dec = d; wr_add = a; wr_half = h; wr_en = 1'b1;
      step();
      wr_en = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 pend in reset", int'(cal_pend), 0);
      chk("R1 en_cnt in reset", int'(en_cnt), 1);
      rst_n = 1'b1;
      p = 0;
      acc = 0;
   endtask

   initial begin
      int prev_exp;
      bit prev_half;
      @(negedge clk);
      do_reset();
      run_to(WIN - 1); step();
      chk("R1 idle window sum", last_sum, WIN);

      prev_exp = WIN;
      prev_half = 1'b0;
      for (int i = 0; i < 12; i++) begin
         logic [8:0] d;
         logic a, h;
         int e;
         d = VEC[i][26:18]; a = VEC[i][17]; h = VEC[i][16]; e = int'(VEC[i][15:0]);
         bad_enc = 0; bad_drop = 0; bad_dbl = 0;
         run_to(5);
         write_cfg(d, a, h);
         chk("R8 pend after write", int'(cal_pend), 1);
         run_to(WIN - 1);
         if (!prev_half) chk("R9 pend held to boundary", int'(cal_pend), 1);
         step();
         chk("R9 pend cleared at boundary", int'(cal_pend), 0);
         if (!prev_half) chk("R8 old setting kept in write window", last_sum, prev_exp);
         run_to(WIN - 1); step();
         if (h)      chk("R5 short window sums", last_sum, e);
         else if (a) chk("R4 add window sum", last_sum, e);
         else        chk("R3 window sum", last_sum, e);
         chk("R2 encoding", int'(bad_enc), 0);
         chk("R6 drop position", int'(bad_drop), 0);
         chk("R7 double position", int'(bad_dbl), 0);
         prev_exp = e;
         prev_half = h;
      end

      // R10: write in the boundary cycle
      run_to(WIN - 1);
      write_cfg(9'd50, 1'b0, 1'b0);
      chk("R10 pend kept after boundary write", int'(cal_pend), 1);
      run_to(WIN - 1);
      chk("R10 pend still high", int'(cal_pend), 1);
      step();
      chk("R10 old setting for one window", last_sum, WIN);
      chk("R10 pend cleared next boundary", int'(cal_pend), 0);
      run_to(WIN - 1); step();
      chk("R10 deferred setting applied", last_sum, WIN - 50);

      // R1: reset discards live and shadow settings
      run_to(5);
      write_cfg(9'd300, 1'b1, 1'b0);
      run_to(100);
      do_reset();
      run_to(WIN - 1);
      chk("R1 pend zero after reset", int'(cal_pend), 0);
      step();
      chk("R1 pass-through after reset", last_sum, WIN);
      run_to(WIN - 1); step();
      chk("R1 shadow cleared by reset", last_sum, WIN);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule